// File: doc/BRIEF.md
# Hierarchical Priority Readout Encoder

This block drains the hit flags of one column of pixels without a scan: it reads out only the pixels that hold a hit. A combinational tree of 4-input arbiter units sits over the flags. Each unit ORs its four inputs into an "any request" signal and reports a 2-bit local index for its winning input. A unit also steers a reset strobe, which comes down from its parent, to that winner alone. With the default of five levels, the tree covers 1024 flags and yields a 10-bit address. No clock runs inside the tree.

A small controller at the top runs the drain. After a `start` pulse it samples the tree once per clock. Whenever any flag is set, it registers the winning address and, in the same cycle, drives a one-hot reset back down the tree to that pixel. The pixel then clears its flag at the clock edge, and the next winner appears. A readout therefore costs one cycle per hit, plus one closing cycle in which the controller finds the tree empty and pulses `done`. Flags that rise while a drain is running take part in it in priority order. The flag storage itself lies outside the block: the block reads `hitState` and returns `pixReset`.

Top module: `prio_readout`

## Requirements
- R1: `anyHit` is 1 exactly when at least one bit of `hitState` is 1, combinationally, whether or not a drain is running.
- R2: The lowest-numbered set flag always wins. With no new flags, a drain emits the addresses in strictly ascending order.
- R3: The address equals the pixel's index in `hitState`. Its top two bits come from the root unit and its bottom two bits from the leaf unit (bits [1:0] select within a group of four flags).
- R4: While busy with a flag set, `pixReset` is one-hot on the current winner. It is never set on a pixel whose flag is 0.
- R5: `start` is accepted in idle, and `busy` rises after that edge. Each following edge at which a flag is set makes `addrValid` 1 for the next cycle and loads `hitAddr` with the winner. A pattern of k hits gives exactly k consecutive address cycles.
- R6: At the first busy edge with no flag set, the block returns to idle and `done` is 1 for exactly one cycle with `addrValid` 0. An empty column gives `done` one cycle after `busy` rises, with no address.
- R7: Flags that rise during a drain are read out in the same drain, in the order given by R2 among the flags still set.
- R8: Outside a drain, `pixReset` is all zero even with flags set. `start` while busy has no effect on the ongoing drain.
- R9: During reset and after it, `busy`, `addrValid` and `done` are 0 and `pixReset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a drain (taken in idle only) |
| hitState | input | 4**LEVELS | Hit flags from the pixels |
| anyHit | output | 1 | Fast-OR of all flags from the tree root |
| busy | output | 1 | A drain is in progress |
| pixReset | output | 4**LEVELS | One-hot clear strobe to the winning pixel |
| addrValid | output | 1 | `hitAddr` carries a new address this cycle |
| hitAddr | output | 2*LEVELS | Address of the last pixel read |
| done | output | 1 | One-cycle pulse when the drain finds no flag |

## Verification
The bench builds the block with LEVELS = 3, which gives 64 pixels and a 6-bit address over three tree levels. This size puts every single-hit position and every pair of hits within reach of an exhaustive sweep. It therefore covers each branch of every unit and each way a reset can travel through two and three levels. Pseudo-random dense patterns, full and empty columns, and a directed case that injects flags during a drain and pulses `start` while busy cover the ordering and timing rules.

// File: rtl/readout_pkg.sv
package readout_pkg;

  // Strobes the controller hands to the datapath each cycle.
  typedef struct packed {
    logic capture;  // load the winning address into the output register
    logic fire;     // send the clear strobe down the tree to the winner
  } drainStrobes_t;

endpackage

// File: rtl/prio_unit.sv
// One 4-input arbiter node: fast-OR upward, local winner index, and
// downward steering of the clear strobe to the winner only.
module prio_unit (
  input  logic [3:0] reqIn,
  input  logic       syncIn,
  output logic       anyReq,
  output logic [1:0] winSel,
  output logic [3:0] syncOut
);

  always_comb begin
    anyReq = |reqIn;
    if (reqIn[0])      winSel = 2'd0;
    else if (reqIn[1]) winSel = 2'd1;
    else if (reqIn[2]) winSel = 2'd2;
    else               winSel = 2'd3;
    syncOut = (syncIn && anyReq) ? (4'd1 << winSel) : 4'd0;
  end

endmodule

// File: rtl/prio_tree.sv
// Recursive arbiter tree built level by level. Each node carries the full
// sub-address of its winner upward, so the root holds the pixel index.
module prio_tree #(
  parameter  int LEVELS = 5,
  localparam int PIX_N  = 1 << (2 * LEVELS),
  localparam int ADDR_W = 2 * LEVELS
) (
  input  logic [PIX_N-1:0]  hitState,
  input  logic              fire,
  output logic              anyHit,
  output logic [ADDR_W-1:0] winAddr,
  output logic [PIX_N-1:0]  pixReset
);

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int NODES = PIX_N >> (2 * l);
    localparam int AW    = 2 * l;

    logic [4*NODES-1:0]  vin;
    logic [NODES-1:0]    v;
    logic [NODES-1:0]    syncIn;
    logic [4*NODES-1:0]  syncOut;
    logic [2*NODES-1:0]  la;
    logic [AW*NODES-1:0] a;

    if (l == 1) begin : g_in
      assign vin = hitState;
    end else begin : g_in
      assign vin = g_lvl[l-1].v;
    end

    if (l == LEVELS) begin : g_sync
      assign syncIn = fire;
    end else begin : g_sync
      assign syncIn = g_lvl[l+1].syncOut;
    end

    for (genvar j = 0; j < NODES; j++) begin : g_node
      prio_unit u_unit (
        .reqIn  (vin[4*j +: 4]),
        .syncIn (syncIn[j]),
        .anyReq (v[j]),
        .winSel (la[2*j +: 2]),
        .syncOut(syncOut[4*j +: 4])
      );

      if (l == 1) begin : g_addr
        assign a[AW*j +: AW] = la[2*j +: 2];
      end else begin : g_addr
        localparam int CW = AW - 2;
        logic [4*CW-1:0] childA;
        assign childA = g_lvl[l-1].a[4*CW*j +: 4*CW];
        assign a[AW*j +: AW] = {la[2*j +: 2], childA[int'(la[2*j +: 2])*CW +: CW]};
      end
    end
  end

  assign anyHit   = g_lvl[LEVELS].v[0];
  assign winAddr  = g_lvl[LEVELS].a;
  assign pixReset = g_lvl[1].syncOut;

endmodule

// File: rtl/readout_dp.sv
// Datapath: the arbiter tree plus the registered address output.
module readout_dp
  import readout_pkg::*;
#(
  parameter  int LEVELS = 5,
  localparam int PIX_N  = 1 << (2 * LEVELS),
  localparam int ADDR_W = 2 * LEVELS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIX_N-1:0]  hitState,
  input  drainStrobes_t     strobes,
  output logic              anyHit,
  output logic [PIX_N-1:0]  pixReset,
  output logic              addrValid,
  output logic [ADDR_W-1:0] hitAddr
);

  logic [ADDR_W-1:0] treeAddr;

  prio_tree #(.LEVELS(LEVELS)) u_tree (
    .hitState(hitState),
    .fire    (strobes.fire),
    .anyHit  (anyHit),
    .winAddr (treeAddr),
    .pixReset(pixReset)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      hitAddr   <= '0;
    end else begin
      addrValid <= strobes.capture;
      if (strobes.capture) hitAddr <= treeAddr;
    end
  end

  assert_fast_or_R1: assert property (@(posedge clk) disable iff (!rstN)
    anyHit == (hitState != '0));

  assert_reset_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pixReset));

  assert_reset_on_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pixReset & ~hitState) == '0);

  assert_addr_matches_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> pixReset[treeAddr]);

  assert_capture_cleared_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> $past(pixReset) != '0);

endmodule

// File: rtl/readout_ctrl.sv
// Control: idle/drain sequencing, one sample of the tree per clock.
module readout_ctrl
  import readout_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          anyHit,
  output drainStrobes_t strobes,
  output logic          busy,
  output logic          done
);

  typedef enum logic {ST_IDLE, ST_DRAIN} ctrlState_t;
  ctrlState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE:  if (start) state <= ST_DRAIN;
        ST_DRAIN: if (!anyHit) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy            = (state == ST_DRAIN);
    strobes.fire    = busy && anyHit;
    strobes.capture = busy && anyHit;
  end

  assert_drain_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && !anyHit |=> done && !busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_no_fire_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strobes.fire);

endmodule

// File: rtl/prio_readout.sv
// Thin top: controller plus datapath.
module prio_readout
  import readout_pkg::*;
#(
  parameter  int LEVELS = 5,
  localparam int PIX_N  = 1 << (2 * LEVELS),
  localparam int ADDR_W = 2 * LEVELS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PIX_N-1:0]  hitState,
  output logic              anyHit,
  output logic              busy,
  output logic [PIX_N-1:0]  pixReset,
  output logic              addrValid,
  output logic [ADDR_W-1:0] hitAddr,
  output logic              done
);

  drainStrobes_t strobes;

  readout_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .anyHit (anyHit),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  readout_dp #(.LEVELS(LEVELS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hitState (hitState),
    .strobes  (strobes),
    .anyHit   (anyHit),
    .pixReset (pixReset),
    .addrValid(addrValid),
    .hitAddr  (hitAddr)
  );

endmodule

// File: tb/prio_readout_tb.sv
`timescale 1ns/1ps
module prio_readout_tb;

  localparam int LV = 3;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [NP-1:0] pix;
  logic [NP-1:0] inject = '0;
  logic          anyHit, busy, addrValid, done;
  logic [NP-1:0] pixReset;
  logic [5:0]    hitAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  prio_readout #(.LEVELS(LV)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .hitState(pix),
    .anyHit(anyHit), .busy(busy), .pixReset(pixReset),
    .addrValid(addrValid), .hitAddr(hitAddr), .done(done)
  );

  // Pixel flag model: set by injection, cleared by the block's strobe.
  always_ff @(posedge clk) begin
    if (!rstN) pix <= '0;
    else       pix <= (pix & ~pixReset) | inject;
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Load a pattern, run one drain and check every cycle of it.
  task automatic drain(logic [NP-1:0] p);
    logic [NP-1:0] rem;
    rem = p;
    @(negedge clk) inject = p;
    @(negedge clk) inject = '0;
    chk(anyHit === (p != '0), "R1 fast-or", longint'(anyHit), longint'(p != '0));
    chk(pixReset === '0, "R8 idle no reset", pixReset, 0);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1 && addrValid === 1'b0, "R5 busy after start", busy, 1);
    while (rem != '0) begin
      int lo;
      lo = lowest(rem);
      chk(pixReset === (64'd1 << lo), "R4 one-hot reset", pixReset, 64'd1 << lo);
      @(negedge clk);
      chk(addrValid === 1'b1 && hitAddr === 6'(lo), "R2 R3 ascending address",
          addrValid ? longint'(hitAddr) : -1, lo);
      rem[lo] = 1'b0;
    end
    chk(anyHit === 1'b0 && busy === 1'b1, "R5 all cleared", anyHit, 0);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0 && addrValid === 1'b0, "R6 done",
        {done, busy, addrValid}, 3'b100);
    @(negedge clk);
    chk(done === 1'b0, "R6 done pulse", done, 0);
  endtask

  initial begin
    logic [63:0] s1, s2;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(busy === 0 && addrValid === 0 && done === 0 && pixReset === '0, "R9 in reset",
        {busy, addrValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 0 && addrValid === 0 && done === 0, "R9 after reset",
        {busy, addrValid, done}, 0);

    // R6 empty column
    drain('0);
    // R3 every single-hit position
    for (int i = 0; i < NP; i++) drain(64'd1 << i);
    // R2 every pair
    for (int i = 0; i < NP; i++)
      for (int j = i + 1; j < NP; j++) drain((64'd1 << i) | (64'd1 << j));
    // R5 full column
    drain('1);
    // R2 pseudo-random dense patterns
    s1 = 64'h9e3779b97f4a7c15;
    s2 = 64'h243f6a8885a308d3;
    for (int k = 0; k < 200; k++) begin
      s1 ^= s1 << 13; s1 ^= s1 >> 7; s1 ^= s1 << 17;
      s2 ^= s2 << 13; s2 ^= s2 >> 7; s2 ^= s2 << 17;
      drain(s1 & s2);
    end

    // R7 flags injected mid-drain, R8 start while busy ignored
    @(negedge clk) inject = (64'd1 << 10) | (64'd1 << 40);
    @(negedge clk) inject = '0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk(addrValid === 1 && hitAddr === 6'd10, "R7 first", hitAddr, 10);
    inject = (64'd1 << 5) | (64'd1 << 60);
    start = 1'b1;
    @(negedge clk);
    inject = '0;
    start = 1'b0;
    chk(addrValid === 1 && hitAddr === 6'd40, "R7 second", hitAddr, 40);
    @(negedge clk);
    chk(addrValid === 1 && hitAddr === 6'd5, "R7 late low hit", hitAddr, 5);
    @(negedge clk);
    chk(addrValid === 1 && hitAddr === 6'd60, "R7 late high hit", hitAddr, 60);
    @(negedge clk);
    chk(done === 1 && busy === 0 && addrValid === 0, "R8 start while busy ignored",
        {done, busy}, 2'b10);
    @(negedge clk);
    chk(busy === 0 && done === 0, "R8 stays idle", busy, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule